// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block is the debug break unit of a small 8-bit microcontroller with a 16-bit address bus. A break can start in two ways. Hardware compares every valid program fetch address with a programmable break address. Software can also request a break by setting a status bit. In both cases the unit raises a request toward the CPU. The CPU honours the request only at its next instruction boundary, where it runs a software interrupt in place of the next opcode. The unit supplies the address of the vector that the software interrupt fetches. That address moves to a second page while the monitor is in control.

Once the break is taken, the unit holds a break-active state until the CPU reports that it has executed a return-from-interrupt. While the break is active, the unit keeps the watchdog counter stopped. A control bit decides whether status flags elsewhere in the chip may be cleared during the break. A break cannot nest inside a break that is already active.

Software reaches four byte-wide registers through a simple read/write port. Offset 0 holds the high byte of the break address and offset 1 holds the low byte. Offset 2 is control and status: bit 0 arms address matching and bit 1 shows or forces the break. Offset 3 is flag control: bit 0 permits flag clearing during a break.

Top module: `brk_match_ctrl`

## Requirements
- R1: After asynchronous reset, the following all read 0: the break address (offsets 0 and 1), the arm bit (offset 2 bit 0), the break status bit (offset 2 bit 1) and the permit bit (offset 3 bit 0). In the same state, brk_req and brk_active are 0 and flag_clr_ok is 1.
- R2: A fetch match raises brk_req on the clock edge that samples it. A fetch matches when the arm bit is 1, fetch_vld is 1, no break is pending or active, and fetch_addr equals {offset 0, offset 1}.
- R3: No request is raised when the arm bit is 0, when fetch_vld is 0, or when fetch_addr differs from the break address.
- R4: A pending request holds brk_req at 1 until a clock edge at which insn_done is 1. At that edge brk_active becomes 1 and brk_req returns to 0.
- R5: Writing offset 2 with bit 1 set to 1 raises brk_req at that edge when no break is active. Offset 2 bit 1 reads 1 while a break is pending or active. Writing offset 2 with bit 1 set to 0 cancels any pending or active break.
- R6: While brk_active is 1, a clock edge with rti_exec at 1 returns brk_active to 0.
- R7: vec_addr is 16'hFFFC when monitor_mode is 0 and 16'hFEFC when monitor_mode is 1.
- R8: wdog_inhibit is 1 exactly while brk_active is 1.
- R9: flag_clr_ok is 1 whenever no break is active. During an active break it equals the permit bit (offset 3 bit 0).
- R10: While a break is active, an address match or a software write of 1 to offset 2 bit 1 is ignored. No request is pending after the break ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_addr | input | 16 | CPU program fetch address |
| fetch_vld | input | 1 | fetch_addr is a valid fetch this cycle |
| insn_done | input | 1 | CPU is at an instruction boundary |
| rti_exec | input | 1 | CPU executed a return-from-interrupt |
| monitor_mode | input | 1 | Monitor mode active |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| brk_req | output | 1 | Break request to CPU |
| brk_active | output | 1 | Break state active |
| wdog_inhibit | output | 1 | Stop watchdog counter |
| flag_clr_ok | output | 1 | Status-flag clearing permitted |
| vec_addr | output | 16 | Break vector address |

## Verification
Directed sequences test an exact match against three near misses: the arm bit off, the fetch strobe low, and an address one off. These separate the address compare from its two qualifiers. Further sequences hold a request across several cycles with no instruction boundary, then take it. This shows that entry waits for the boundary and does not follow the match. Matches and software sets issued during an active break, and RTI arriving together with a match, show that breaks do not nest. A constrained-random phase mixes fetches near the break address, boundaries, RTIs, monitor toggles and control writes. Its results are compared every cycle with a bench model of the request and active state.

// File: rtl/brk_pkg.sv
package brk_pkg;
   // software command decoded from a write to the control/status register
   typedef struct packed {
      logic set;   // force a break
      logic clr;   // cancel pending or active break
   } brk_swcmd_t;

   localparam int unsigned ARM_BIT  = 0;
   localparam int unsigned STAT_BIT = 1;
   localparam int unsigned PERM_BIT = 0;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
   import brk_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NBYTES = ADDR_W / DATA_W,
   localparam int unsigned RAW    = $clog2(NBYTES + 2)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW-1:0]    reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              status_in,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] bp_addr,
   output logic              arm,
   output logic              permit,
   output brk_swcmd_t        swcmd
);
   localparam int unsigned CTRL_OFF = NBYTES;
   localparam int unsigned FLAG_OFF = NBYTES + 1;

   generate
      if (ADDR_W % DATA_W != 0) begin : g_bad_split
         $error("ADDR_W must be a multiple of DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must hold the control bits");
      end
   endgenerate

   logic [NBYTES-1:0][DATA_W-1:0] bp_q;
   logic ctrl_wr;

   assign bp_addr = bp_q;
   assign ctrl_wr = reg_wr && (reg_addr == RAW'(CTRL_OFF));
   assign swcmd.set = ctrl_wr && reg_wdata[STAT_BIT];
   assign swcmd.clr = ctrl_wr && !reg_wdata[STAT_BIT];

   // offset 0 is the most significant byte
   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bp_q[NBYTES-1-i] <= '0;
            else if (reg_wr && reg_addr == RAW'(i))
               bp_q[NBYTES-1-i] <= reg_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm    <= 1'b0;
         permit <= 1'b0;
      end else begin
         if (ctrl_wr)
            arm <= reg_wdata[ARM_BIT];
         if (reg_wr && reg_addr == RAW'(FLAG_OFF))
            permit <= reg_wdata[PERM_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NBYTES; i++)
         if (reg_addr == RAW'(i))
            reg_rdata = bp_q[NBYTES-1-i];
      if (reg_addr == RAW'(CTRL_OFF)) begin
         reg_rdata[ARM_BIT]  = arm;
         reg_rdata[STAT_BIT] = status_in;
      end
      if (reg_addr == RAW'(FLAG_OFF))
         reg_rdata[PERM_BIT] = permit;
   end
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NBYTES = ADDR_W / DATA_W
)(
   input  logic              arm,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [ADDR_W-1:0] bp_addr,
   output logic              hit
);
   logic [NBYTES-1:0] byte_eq;

   // byte-sliced compare, reduced by an AND tree
   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_eq
         assign byte_eq[i] = fetch_addr[i*DATA_W +: DATA_W] == bp_addr[i*DATA_W +: DATA_W];
      end
   endgenerate

   assign hit = arm && fetch_vld && (&byte_eq);
endmodule

// File: rtl/brk_seq.sv
module brk_seq
   import brk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  brk_swcmd_t swcmd,
   input  logic       boundary,
   input  logic       rti,
   output logic       pending,
   output logic       active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         active  <= 1'b0;
      end else if (swcmd.clr) begin
         pending <= 1'b0;
         active  <= 1'b0;
      end else if (active) begin
         if (rti)
            active <= 1'b0;
      end else if (pending) begin
         if (boundary) begin
            active  <= 1'b1;
            pending <= 1'b0;
         end
      end else if (hit || swcmd.set) begin
         pending <= 1'b1;
      end
   end

   p_no_nest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending && active));

   p_enter_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && boundary && !swcmd.clr) |=> (active && !pending));

   p_hold_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !boundary && !swcmd.clr) |=> pending);

   p_rti_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rti) |=> !active);

   p_req_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !active && !hit && !swcmd.set) |=> !pending);
endmodule

// File: rtl/brk_match_ctrl.sv
module brk_match_ctrl
   import brk_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 16,
   parameter int unsigned        DATA_W   = 8,
   parameter logic [ADDR_W-1:0]  NORM_VEC = 16'hFFFC,
   parameter logic [ADDR_W-1:0]  MON_VEC  = 16'hFEFC,
   localparam int unsigned       NBYTES   = ADDR_W / DATA_W,
   localparam int unsigned       RAW      = $clog2(NBYTES + 2)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_vld,
   input  logic              insn_done,
   input  logic              rti_exec,
   input  logic              monitor_mode,
   input  logic [RAW-1:0]    reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              brk_req,
   output logic              brk_active,
   output logic              wdog_inhibit,
   output logic              flag_clr_ok,
   output logic [ADDR_W-1:0] vec_addr
);
   generate
      if (ADDR_W < DATA_W) begin : g_bad_bus
         $error("ADDR_W must be at least DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] bp_addr;
   logic              arm, permit, hit, pending, active;
   brk_swcmd_t        swcmd;

   brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .status_in(pending | active), .reg_rdata(reg_rdata),
      .bp_addr(bp_addr), .arm(arm), .permit(permit), .swcmd(swcmd)
   );

   brk_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .arm(arm), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .bp_addr(bp_addr), .hit(hit)
   );

   brk_seq u_seq (
      .clk(clk), .rst_n(rst_n), .hit(hit), .swcmd(swcmd),
      .boundary(insn_done), .rti(rti_exec), .pending(pending), .active(active)
   );

   assign brk_req      = pending;
   assign brk_active   = active;
   assign wdog_inhibit = active;
   assign flag_clr_ok  = !active || permit;
   assign vec_addr     = monitor_mode ? MON_VEC : NORM_VEC;

   p_flag_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_active |-> flag_clr_ok);

   p_entry_from_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_active) |-> $past(brk_req));

   p_wdog_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk_active) |-> !wdog_inhibit);
endmodule

// File: tb/brk_match_ctrl_tb.sv
module brk_match_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic        fetch_vld = 1'b0, insn_done = 1'b0, rti_exec = 1'b0, monitor_mode = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        brk_req, brk_active, wdog_inhibit, flag_clr_ok;
   logic [15:0] vec_addr;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // bench model of the programmed state
   logic [15:0] m_bp = '0;
   logic m_arm = 0, m_perm = 0, m_pend = 0, m_act = 0;

   always #10 clk = ~clk;

   brk_match_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
      .insn_done(insn_done), .rti_exec(rti_exec), .monitor_mode(monitor_mode),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .brk_req(brk_req), .brk_active(brk_active), .wdog_inhibit(wdog_inhibit),
      .flag_clr_ok(flag_clr_ok), .vec_addr(vec_addr)
   );

   function automatic logic [15:0] exp_vec(input logic mon);
      return mon ? 16'hFEFC : 16'hFFFC;
   endfunction

   function automatic logic exp_flag(input logic act, input logic perm);
      return !act || perm;
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_outputs(input string tag);
      chk({tag, " brk_req"}, 16'(brk_req), 16'(m_pend));
      chk({tag, " brk_active"}, 16'(brk_active), 16'(m_act));
      chk("R8 wdog_inhibit", 16'(wdog_inhibit), 16'(m_act));
      chk("R9 flag_clr_ok", 16'(flag_clr_ok), 16'(exp_flag(m_act, m_perm)));
      chk("R7 vec_addr", vec_addr, exp_vec(monitor_mode));
   endtask

   // one clock: model the next state from current inputs, then compare
   task automatic tick(input string tag);
      logic hit, sclr, sset;
      logic n_pend, n_act;
      hit  = m_arm && fetch_vld && fetch_addr == m_bp;
      sclr = reg_wr && reg_addr == 2'd2 && !reg_wdata[1];
      sset = reg_wr && reg_addr == 2'd2 && reg_wdata[1];
      n_pend = m_pend; n_act = m_act;
      if (sclr) begin n_pend = 0; n_act = 0; end
      else if (m_act) begin if (rti_exec) n_act = 0; end
      else if (m_pend) begin if (insn_done) begin n_act = 1; n_pend = 0; end end
      else if (hit || sset) n_pend = 1;
      if (reg_wr) begin
         case (reg_addr)
            2'd0: m_bp[15:8] = reg_wdata;
            2'd1: m_bp[7:0]  = reg_wdata;
            2'd2: m_arm      = reg_wdata[0];
            default: m_perm  = reg_wdata[0];
         endcase
      end
      m_pend = n_pend; m_act = n_act;
      @(posedge clk); #1;
      reg_wr = 0; fetch_vld = 0; insn_done = 0; rti_exec = 0;
      check_outputs(tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      tick(tag);
   endtask

   task automatic fetch(input logic [15:0] a, input string tag);
      fetch_addr = a; fetch_vld = 1;
      tick(tag);
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a; #1;
      chk(tag, 16'(reg_rdata), 16'(exp));
   endtask

   initial begin
      void'($urandom(32'd4242));
      #45 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      check_outputs("R1 reset");
      rd(2'd0, 8'h00, "R1 bp high");
      rd(2'd1, 8'h00, "R1 bp low");
      rd(2'd2, 8'h00, "R1 ctrl");
      rd(2'd3, 8'h00, "R1 flagctl");

      // R2 program and match
      wr(2'd0, 8'h12, "R2 wr hi");
      wr(2'd1, 8'h34, "R2 wr lo");
      wr(2'd2, 8'h01, "R2 arm");
      rd(2'd0, 8'h12, "R2 readback hi");
      rd(2'd1, 8'h34, "R2 readback lo");
      fetch(16'h1234, "R2 match");
      // R4 hold without boundary
      tick("R4 hold");
      tick("R4 hold");
      rd(2'd2, 8'h03, "R5 status while pending");
      insn_done = 1; tick("R4 enter");
      rd(2'd2, 8'h03, "R5 status while active");
      monitor_mode = 1; tick("R7 monitor");
      // R10 no nesting
      fetch(16'h1234, "R10 match ignored");
      wr(2'd2, 8'h03, "R10 sw set ignored");
      fetch_addr = 16'h1234; fetch_vld = 1; rti_exec = 1; tick("R6 rti with match");
      tick("R10 nothing pending");
      monitor_mode = 0;

      // R3 misses
      fetch(16'h1235, "R3 addr differs");
      fetch(16'h0234, "R3 high byte differs");
      fetch_addr = 16'h1234; tick("R3 no fetch_vld");
      wr(2'd2, 8'h00, "R3 disarm");
      fetch(16'h1234, "R3 disarmed");

      // R5 software break and cancel
      wr(2'd2, 8'h02, "R5 sw set");
      wr(2'd2, 8'h00, "R5 sw cancel pending");
      rd(2'd2, 8'h00, "R5 status cleared");
      wr(2'd2, 8'h02, "R5 sw set again");
      insn_done = 1; tick("R5 enter");
      wr(2'd2, 8'h00, "R5 sw cancel active");

      // R9 permit during break
      wr(2'd3, 8'h01, "R9 permit");
      rd(2'd3, 8'h01, "R9 readback");
      wr(2'd2, 8'h02, "R9 sw set");
      insn_done = 1; tick("R9 active permit");
      rti_exec = 1; tick("R6 rti");

      // random mix around the break address
      wr(2'd2, 8'h01, "R2 rearm");
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         fetch_addr   = r[0] ? 16'h1234 : (16'h1234 ^ (16'h1 << r[4:1]));
         fetch_vld    = r[5];
         insn_done    = r[6] & r[7];
         rti_exec     = r[8] & r[9];
         monitor_mode = r[10];
         if (r[15:11] == 5'd0) begin
            reg_addr = r[17:16]; reg_wdata = r[25:18]; reg_wr = 1;
            if (r[17:16] < 2'd2) reg_wdata = r[16] ? 8'h34 : 8'h12;
            if (r[17:16] == 2'd2) reg_wdata = {6'd0, r[19], 1'b1};
         end
         tick("R2 random");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule